// File: doc/BRIEF.md
# Parallel Crosspoint Command Decoder

This block is the parallel programming front end of an eight-output video routing matrix. A host presents a 7-bit word, made of a 3-bit output address and a 4-bit command, and pulses a write strobe. The strobe counts only while both chip selects are active: the high-true select is 1 and the low-true select is 0. One 4-bit command space holds both the route selections and a set of control actions. Route selections are held in a per-output staging register, called the master. The control actions switch output enables on or off right away, or request a software transfer from the masters to the applied routes.

Each output also has an applied register, called the slave, and the matrix is driven from the slaves. The slaves take the staged routes in one of two ways, chosen by a strap. In edge mode the transfer happens on a rising edge of the latch input. In level mode the slaves follow the masters for as long as the latch input is low. A host can therefore stage several routes and then switch them all in one cycle, or it can let each route take effect as soon as it is written. All logic runs on one system clock. The write strobe and the latch input are both sampled, and their rising edges are detected against a registered copy.

Top module: `xpt_par_decoder`

## Requirements
- R1: While reset is asserted, and directly after it, every output enable is 0 and every applied route code is 0 (input 0).
- R2: A word is accepted only in the cycle where the gated strobe (wr_strb=1, chip_sel=1, chip_sel_n=0) is first sampled high after being low. Holding the strobe high does not accept the word again, and a strobe with either select inactive has no effect.
- R3: Command values 0 to 7 stage that input index, and value 8 stages the ground code 8, in the addressed output's master. These commands never change any enable.
- R4: Command 11 clears the enable of the addressed output and command 12 sets it. Other enables and all route registers are left as they were.
- R5: Command 13 clears every enable and command 14 sets every enable, whatever the address.
- R6: Commands 11 to 14 change the enables in the clock after the accepted edge, in either mode and at either latch level.
- R7: Command 15 copies every master into its slave when the latch input is 1 at the accepted edge. When the latch input is 0, the command does nothing.
- R8: In edge mode (edge_mode=1), slaves load from the masters only on a sampled rising edge of latch_strb (or through R7). A staged route is not visible before that edge.
- R9: In level mode (edge_mode=0), slaves follow the masters while latch_strb is 0, so a route written with the latch low is applied in the clock after the write edge. While latch_strb is 1, the slaves hold.
- R10: The reserved command values 9 and 10 change neither any enable nor any master.
- R11: When an accepted write and a latch rising edge are sampled in the same cycle, the slave takes the newly written master value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_strb | input | 1 | Write strobe, sampled for rising edges |
| chip_sel | input | 1 | High-true chip select gating the strobe |
| chip_sel_n | input | 1 | Low-true chip select gating the strobe |
| out_addr | input | 3 | Output addressed by the word |
| cmd_word | input | 4 | Route code or control command |
| latch_strb | input | 1 | Transfer control for the applied routes |
| edge_mode | input | 1 | Strap: 1 selects edge transfer, 0 selects level transfer |
| route_code | output | 32 | Applied 4-bit route per output, output k in bits 4k+3:4k |
| out_en | output | 8 | Enable flag per output |

## Verification
The bench stages routes in edge mode and checks that they stay hidden until a latch rising edge. A design that wired the slaves straight through would show the new routes early. It then drives the software latch with the latch input both high and low, which catches a decoder that ignores the level condition. It also holds the strobe high while changing the command, and drives it with each chip select inactive. A missing edge detector or gate would then apply the second command. It further sends the reserved codes, which a loose range decode would treat as routes or disables. Finally it lands a write and a latch rise in the same cycle, where a design ordering the two the wrong way would apply the old route.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int CMD_W = 4;
  typedef logic [CMD_W-1:0] cmd_t;

  localparam cmd_t CMD_GND     = 4'd8;
  localparam cmd_t CMD_OFF_ONE = 4'd11;
  localparam cmd_t CMD_ON_ONE  = 4'd12;
  localparam cmd_t CMD_OFF_ALL = 4'd13;
  localparam cmd_t CMD_ON_ALL  = 4'd14;
  localparam cmd_t CMD_SW_LAT  = 4'd15;

  typedef struct packed {
    logic route_we;
    logic off_one;
    logic on_one;
    logic off_all;
    logic on_all;
    logic sw_latch;
  } act_t;
endpackage

// File: rtl/xpt_rise_det.sv
module xpt_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;
  logic prev_d;

  always_comb prev_d = sig_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/xpt_cmd_decode.sv
module xpt_cmd_decode
  import xpt_pkg::*;
(
  input  logic fire_i,
  input  logic latch_i,
  input  cmd_t cmd_i,
  output act_t act_o
);
  always_comb begin
    act_o          = '0;
    act_o.route_we = fire_i & (cmd_i <= CMD_GND);
    act_o.off_one  = fire_i & (cmd_i == CMD_OFF_ONE);
    act_o.on_one   = fire_i & (cmd_i == CMD_ON_ONE);
    act_o.off_all  = fire_i & (cmd_i == CMD_OFF_ALL);
    act_o.on_all   = fire_i & (cmd_i == CMD_ON_ALL);
    act_o.sw_latch = fire_i & (cmd_i == CMD_SW_LAT) & latch_i;
  end
endmodule

// File: rtl/xpt_route_bank.sv
module xpt_route_bank
  import xpt_pkg::*;
#(
  parameter int N_OUT = 8,
  localparam int AW = $clog2(N_OUT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   route_we,
  input  logic                   sw_latch,
  input  logic [AW-1:0]          addr_i,
  input  cmd_t                   cmd_i,
  input  logic                   edge_mode,
  input  logic                   latch_lvl,
  input  logic                   latch_rise,
  output logic [N_OUT*CMD_W-1:0] route_o
);
  logic xfer;

  // master update happens first; the slave transfer sees the new master
  always_comb xfer = sw_latch | (edge_mode ? latch_rise : ~latch_lvl);

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    localparam logic [AW-1:0] MY_ADDR = AW'(i);
    cmd_t mst_q, mst_d, slv_q, slv_d;
    logic mst_ce;

    always_comb begin
      mst_ce = route_we & (addr_i == MY_ADDR);
      mst_d  = mst_ce ? cmd_i : mst_q;
      slv_d  = xfer ? mst_d : slv_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mst_q <= '0;
        slv_q <= '0;
      end else begin
        if (mst_ce) mst_q <= mst_d;
        if (xfer)   slv_q <= slv_d;
      end
    end

    assign route_o[i*CMD_W +: CMD_W] = slv_q;
  end
endmodule

// File: rtl/xpt_enable_bank.sv
module xpt_enable_bank
  import xpt_pkg::*;
#(
  parameter int N_OUT = 8,
  localparam int AW = $clog2(N_OUT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  act_t             act_i,
  input  logic [AW-1:0]    addr_i,
  output logic [N_OUT-1:0] en_o
);
  logic [N_OUT-1:0] en_q, en_d;
  logic             en_ce;

  always_comb begin
    en_ce = act_i.off_one | act_i.on_one | act_i.off_all | act_i.on_all;
    for (int i = 0; i < N_OUT; i++) begin
      if (act_i.off_all)                                 en_d[i] = 1'b0;
      else if (act_i.on_all)                             en_d[i] = 1'b1;
      else if (act_i.off_one && addr_i == AW'(i))        en_d[i] = 1'b0;
      else if (act_i.on_one && addr_i == AW'(i))         en_d[i] = 1'b1;
      else                                               en_d[i] = en_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/xpt_par_decoder.sv
module xpt_par_decoder
  import xpt_pkg::*;
#(
  parameter int N_OUT = 8,
  localparam int AW = $clog2(N_OUT),
  localparam int RW = N_OUT * CMD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_strb,
  input  logic             chip_sel,
  input  logic             chip_sel_n,
  input  logic [AW-1:0]    out_addr,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             latch_strb,
  input  logic             edge_mode,
  output logic [RW-1:0]    route_code,
  output logic [N_OUT-1:0] out_en
);
  logic wr_gated;
  logic wr_fire;
  logic lat_rise;
  act_t act;

  assign wr_gated = wr_strb & chip_sel & ~chip_sel_n;

  xpt_rise_det u_wr_det (
    .clk(clk), .rst_n(rst_n), .sig_i(wr_gated), .rise_o(wr_fire)
  );

  xpt_rise_det u_lat_det (
    .clk(clk), .rst_n(rst_n), .sig_i(latch_strb), .rise_o(lat_rise)
  );

  xpt_cmd_decode u_dec (
    .fire_i(wr_fire), .latch_i(latch_strb), .cmd_i(cmd_word), .act_o(act)
  );

  xpt_route_bank #(.N_OUT(N_OUT)) u_routes (
    .clk(clk), .rst_n(rst_n),
    .route_we(act.route_we), .sw_latch(act.sw_latch),
    .addr_i(out_addr), .cmd_i(cmd_word),
    .edge_mode(edge_mode), .latch_lvl(latch_strb), .latch_rise(lat_rise),
    .route_o(route_code)
  );

  xpt_enable_bank #(.N_OUT(N_OUT)) u_enables (
    .clk(clk), .rst_n(rst_n), .act_i(act), .addr_i(out_addr), .en_o(out_en)
  );
endmodule

// File: rtl/xpt_par_decoder_chk.sv
module xpt_par_decoder_chk #(
  parameter int N_OUT = 8,
  localparam int AW = $clog2(N_OUT),
  localparam int RW = N_OUT * 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_strb,
  input logic             chip_sel,
  input logic             chip_sel_n,
  input logic [AW-1:0]    out_addr,
  input logic [3:0]       cmd_word,
  input logic             latch_strb,
  input logic             edge_mode,
  input logic [RW-1:0]    route_code,
  input logic [N_OUT-1:0] out_en
);
  logic g_prev, l_prev, acc, lrise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_prev <= 1'b0;
      l_prev <= 1'b0;
    end else begin
      g_prev <= wr_strb & chip_sel & ~chip_sel_n;
      l_prev <= latch_strb;
    end
  end

  assign acc   = wr_strb & chip_sel & ~chip_sel_n & ~g_prev;
  assign lrise = latch_strb & ~l_prev;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (out_en == '0 && route_code == '0));

  // R3
  route_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_word <= 4'd8) |=> $stable(out_en));

  // R4
  off_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_word == 4'd11) |=> !out_en[$past(out_addr)]);

  // R4
  on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_word == 4'd12) |=> out_en[$past(out_addr)]);

  // R5
  off_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_word == 4'd13) |=> out_en == '0);

  // R5
  on_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_word == 4'd14) |=> out_en == '1);

  // R8
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !lrise && !(acc && cmd_word == 4'd15 && latch_strb))
      |=> $stable(route_code));

  // R9
  level_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && !latch_strb && acc && cmd_word <= 4'd8)
      |=> route_code[4*int'($past(out_addr)) +: 4] == $past(cmd_word));

  // R10
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd_word == 4'd9 || cmd_word == 4'd10)) |=> $stable(out_en));
endmodule

bind xpt_par_decoder xpt_par_decoder_chk #(.N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_strb(wr_strb), .chip_sel(chip_sel),
  .chip_sel_n(chip_sel_n), .out_addr(out_addr), .cmd_word(cmd_word),
  .latch_strb(latch_strb), .edge_mode(edge_mode),
  .route_code(route_code), .out_en(out_en)
);

// File: tb/tb_xpt_par_decoder.sv
module tb_xpt_par_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n, wr_strb, chip_sel, chip_sel_n, latch_strb, edge_mode;
  logic [2:0]  out_addr;
  logic [3:0]  cmd_word;
  logic [31:0] route_code;
  logic [7:0]  out_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  xpt_par_decoder dut (
    .clk(clk), .rst_n(rst_n), .wr_strb(wr_strb), .chip_sel(chip_sel),
    .chip_sel_n(chip_sel_n), .out_addr(out_addr), .cmd_word(cmd_word),
    .latch_strb(latch_strb), .edge_mode(edge_mode),
    .route_code(route_code), .out_en(out_en)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string phase = "R1";

  // behavioural reference model
  int m_mst[N];
  int m_slv[N];
  bit m_en[N];
  bit m_wp, m_lp, m_g, m_acc, m_lr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_mst[i] = 0; m_slv[i] = 0; m_en[i] = 0; end
      m_wp = 0; m_lp = 0;
    end else begin
      m_g   = wr_strb && chip_sel && !chip_sel_n;
      m_acc = m_g && !m_wp;
      m_lr  = latch_strb && !m_lp;
      m_wp  = m_g;
      m_lp  = latch_strb;
      if (m_acc) begin
        if (cmd_word <= 8) m_mst[out_addr] = cmd_word;
        else if (cmd_word == 11) m_en[out_addr] = 0;
        else if (cmd_word == 12) m_en[out_addr] = 1;
        else if (cmd_word == 13) for (int i = 0; i < N; i++) m_en[i] = 0;
        else if (cmd_word == 14) for (int i = 0; i < N; i++) m_en[i] = 1;
        else if (cmd_word == 15 && latch_strb)
          for (int i = 0; i < N; i++) m_slv[i] = m_mst[i];
      end
      if (edge_mode ? m_lr : !latch_strb)
        for (int i = 0; i < N; i++) m_slv[i] = m_mst[i];
    end
  end

  logic [31:0] exp_r;
  logic [7:0]  exp_e;
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      for (int i = 0; i < N; i++) begin
        exp_r[4*i +: 4] = 4'(m_slv[i]);
        exp_e[i]        = m_en[i];
      end
      n_cmp++;
      if (route_code !== exp_r || out_en !== exp_e) begin
        n_bad++;
        $display("FAIL %s model: route=%h en=%h expected route=%h en=%h",
                 phase, route_code, out_en, exp_r, exp_e);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(input int a, input int c);
    @(negedge clk);
    out_addr = 3'(a); cmd_word = 4'(c); wr_strb = 1'b1;
    @(negedge clk);
    wr_strb = 1'b0;
  endtask

  task automatic latch_pulse();
    @(negedge clk); latch_strb = 1'b0;
    @(negedge clk); latch_strb = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; wr_strb = 0; chip_sel = 1; chip_sel_n = 0;
    out_addr = 0; cmd_word = 0; latch_strb = 1; edge_mode = 1;
    repeat (3) @(negedge clk);
    chk("R1", {24'd0, out_en}, 32'h0);
    chk("R1", route_code, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", route_code, 32'h0);

    phase = "R8";
    for (int i = 0; i < N; i++) wr_word(i, 7 - i);
    chk("R8", route_code, 32'h0);
    chk("R3", {24'd0, out_en}, 32'h0);

    phase = "R5";
    wr_word(5, 14);
    chk("R5", {24'd0, out_en}, 32'hFF);
    phase = "R8";
    latch_pulse();
    chk("R8", route_code, 32'h01234567);

    phase = "R4";
    wr_word(3, 11);
    chk("R4", {24'd0, out_en}, 32'hF7);
    chk("R4", route_code, 32'h01234567);
    wr_word(3, 12);
    chk("R4", {24'd0, out_en}, 32'hFF);
    phase = "R5";
    wr_word(6, 13);
    chk("R5", {24'd0, out_en}, 32'h00);
    wr_word(1, 14);
    chk("R6", {24'd0, out_en}, 32'hFF);

    phase = "R2";
    chip_sel = 0;
    wr_word(0, 5);
    chip_sel = 1; chip_sel_n = 1;
    wr_word(1, 13);
    chk("R2", {24'd0, out_en}, 32'hFF);
    chip_sel_n = 0;
    latch_pulse();
    chk("R2", route_code, 32'h01234567);
    @(negedge clk); out_addr = 1; cmd_word = 11; wr_strb = 1;
    @(negedge clk);
    chk("R2", {24'd0, out_en}, 32'hFD);
    cmd_word = 12;
    @(negedge clk); @(negedge clk);
    chk("R2", {24'd0, out_en}, 32'hFD);
    wr_strb = 0;
    wr_word(1, 12);
    chk("R4", {24'd0, out_en}, 32'hFF);

    phase = "R10";
    wr_word(2, 9);
    chk("R10", {24'd0, out_en}, 32'hFF);
    wr_word(2, 10);
    chk("R10", {24'd0, out_en}, 32'hFF);
    latch_pulse();
    chk("R10", route_code, 32'h01234567);

    phase = "R7";
    wr_word(0, 2);
    chk("R8", route_code, 32'h01234567);
    wr_word(5, 15);
    chk("R7", route_code, 32'h01234562);
    wr_word(0, 4);
    @(negedge clk); latch_strb = 0;
    wr_word(3, 15);
    chk("R7", route_code, 32'h01234562);
    @(negedge clk); latch_strb = 1;
    @(negedge clk);
    chk("R8", route_code, 32'h01234564);

    phase = "R9";
    @(negedge clk); edge_mode = 0;
    wr_word(1, 3);
    chk("R9", route_code, 32'h01234564);
    @(negedge clk); latch_strb = 0;
    @(negedge clk);
    chk("R9", route_code, 32'h01234534);
    wr_word(2, 8);
    chk("R9", route_code, 32'h01234834);
    wr_word(6, 11);
    chk("R6", {24'd0, out_en}, 32'hBF);
    wr_word(6, 12);
    chk("R6", {24'd0, out_en}, 32'hFF);

    phase = "R11";
    @(negedge clk); edge_mode = 1;
    @(negedge clk);
    chk("R11", route_code, 32'h01234834);
    out_addr = 4; cmd_word = 6; wr_strb = 1; latch_strb = 1;
    @(negedge clk);
    wr_strb = 0;
    chk("R11", route_code, 32'h01264834);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule